// File: doc/BRIEF.md
# DMA End-of-Transfer Terminator

This block watches a DMA transfer between an external DMA controller and one selected endpoint FIFO and decides the cycle in which that transfer must end. Three sources can end it: a falling edge on the external end-of-transfer pin (active low, asynchronous), a programmable byte counter reaching zero, and the draining of a short packet from an OUT endpoint. None of these sources raises an interrupt. The block emits a one-cycle stop pulse and ignores further strobes until software clears and sets the enable again.

At the stop, the block takes one action, and that action depends on the FIFO direction. For an OUT endpoint with bytes still unread in the active buffer half, it pulses a flush for that half only. For an IN endpoint, it pulses a commit for the active half, so that the partial packet goes out at the next IN token. The other half of a double buffer is never touched.

Top module: `dma_eot_term`

## Requirements
- R1: A falling edge of `eot_n` while `dma_active` is 1 produces `dma_stop` = 1 in the sample taken after the third rising clock edge that follows the fall. If the pin is held low, it ends only one transfer: re-enabling DMA while the pin stays low produces no further stop.
- R2: With `cnt_en` = 1, each beat (`dma_strobe` and `dma_ack` both high while active) lowers the count loaded by `cnt_load` by 1 when `width16` = 0 and by 2 when `width16` = 1. The beat that brings the count to zero or below ends the transfer, and `dma_stop` rises on the clock edge of that beat, so a count of N ends after ceil(N/step) beats.
- R3: With `cnt_en` = 0, the counter never ends a transfer.
- R4: With `short_en` = 1, `dir_in` = 0 and `pkt_short` = 1, a beat taken while `fifo_level` is at most the step size ends the transfer. Short-packet mode has no effect when `short_en` = 0 or when `dir_in` = 1.
- R5: Causes that coincide produce one single-cycle `dma_stop` pulse. After a stop, `dma_active` is 0 and further beats produce no stop until `dma_en` has been 0 for at least one clock.
- R6: When a stop occurs on an OUT endpoint (`dir_in` = 0), `flush_out` bit `buf_sel` pulses together with `dma_stop` only if bytes remain after the terminating beat (remaining = `fifo_level` minus step, floored at 0). The other `flush_out` bit stays 0, and `commit_in` stays 0.
- R7: When a stop occurs on an IN endpoint (`dir_in` = 1), `commit_in` bit `buf_sel` pulses together with `dma_stop`, and `flush_out` stays 0.
- R8: While `dma_en` = 0, `dma_active` is 0, beats do not change the count, and `eot_n` edges produce no stop.
- R9: After reset, `dma_stop`, `flush_out` and `commit_in` are 0. `dma_active` equals `dma_en` whenever no stop has happened since the last time `dma_en` was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | DMA enable; 0 disables DMA and re-arms after a stop |
| width16 | input | 1 | DMA width: 0 = 8-bit (step 1), 1 = 16-bit (step 2) |
| cnt_en | input | 1 | Byte counter termination enable |
| cnt_load | input | 1 | Load `cnt_init` into the byte counter |
| cnt_init | input | CNT_W | Transfer byte count |
| short_en | input | 1 | Short-packet termination enable |
| dir_in | input | 1 | Endpoint direction: 1 = IN, 0 = OUT |
| eot_n | input | 1 | External end-of-transfer pin, active low, asynchronous |
| dma_strobe | input | 1 | DMA data strobe |
| dma_ack | input | 1 | DMA acknowledge |
| fifo_level | input | LVL_W | Bytes in the active buffer half before this beat |
| pkt_short | input | 1 | Active OUT buffer holds a short packet |
| buf_sel | input | SEL_W | Index of the active buffer half |
| dma_active | output | 1 | Transfer in progress |
| dma_stop | output | 1 | One-cycle end-of-transfer pulse |
| flush_out | output | NBUF | Flush command per OUT buffer half |
| commit_in | output | NBUF | Commit command per IN buffer half |

## Verification
The counter is swept over both widths, counts 1 to 6, both buffer halves and both directions. Each run checks that the stop arrives exactly on beat ceil(N/step) and not before, and that the action goes to the right half and matches the direction. Separate patterns drive the short-packet path with descending levels under each width, and with the mode off or the direction set to IN. They also drive a residue of exactly zero against a residue of one byte, which separates flush from no flush. The external pin is tested for its three-cycle synchronizer latency and for its one-shot behaviour when held low. The pin edge is also made to coincide with the terminal counter beat, to show that a single pulse comes out, and is applied while DMA is disabled, to show that both strobes and edges are ignored then.

// File: rtl/dma_eot_pkg.sv
package dma_eot_pkg;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } ep_dir_e;

    typedef struct packed {
        logic ext_hit;
        logic cnt_hit;
        logic shp_hit;
    } eot_cause_t;

    function automatic logic [1:0] beat_step(input logic wide);
        return wide ? 2'd2 : 2'd1;
    endfunction

    function automatic logic any_cause(input eot_cause_t c);
        return c.ext_hit | c.cnt_hit | c.shp_hit;
    endfunction

endpackage

// File: rtl/dma_eot_sync.sv
module dma_eot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], pin_n};
    end

    // older stage still high, newer stage low: one-cycle falling edge
    assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/dma_eot_counter.sv
module dma_eot_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    input  logic             beat,
    input  logic [1:0]       step,
    input  logic             enable,
    output logic             hit
);
    logic signed [CNT_W:0] cnt;
    logic signed [CNT_W:0] step_s;
    logic signed [CNT_W:0] nxt;

    assign step_s = $signed({{(CNT_W-1){1'b0}}, step});
    assign nxt    = cnt - step_s;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= $signed({1'b0, init});
        else if (beat) cnt <= nxt;
    end

    assign hit = enable & beat & ~load & (nxt <= 0);
endmodule

// File: rtl/dma_eot_action.sv
module dma_eot_action
    import dma_eot_pkg::*;
#(
    parameter int NBUF  = 2,
    parameter int LVL_W = 11,
    localparam int SEL_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_en,
    input  eot_cause_t       cause,
    input  ep_dir_e          dir,
    input  logic [SEL_W-1:0] sel,
    input  logic [LVL_W-1:0] level,
    input  logic             beat,
    input  logic [1:0]       step,
    output logic             active,
    output logic             stop,
    output logic [NBUF-1:0]  flush,
    output logic [NBUF-1:0]  commit
);
    logic             done;
    logic             fire;
    logic [LVL_W-1:0] step_l;
    logic [LVL_W-1:0] left;
    logic [NBUF-1:0]  sel_oh;

    assign active = dma_en & ~done;
    assign fire   = active & any_cause(cause);
    assign step_l = {{(LVL_W-2){1'b0}}, step};
    assign left   = !beat ? level : ((level > step_l) ? level - step_l : '0);

    for (genvar b = 0; b < NBUF; b++) begin : g_sel
        assign sel_oh[b] = (sel == SEL_W'(b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            stop   <= 1'b0;
            flush  <= '0;
            commit <= '0;
        end else begin
            stop   <= fire;
            flush  <= (fire && dir == DIR_OUT && left != '0) ? sel_oh : '0;
            commit <= (fire && dir == DIR_IN) ? sel_oh : '0;
            if (!dma_en)   done <= 1'b0;
            else if (fire) done <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_eot_term.sv
module dma_eot_term
    import dma_eot_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 11,
    parameter int NBUF  = 2,
    parameter int SYNC  = 2,
    localparam int SEL_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_en,
    input  logic             width16,
    input  logic             cnt_en,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_init,
    input  logic             short_en,
    input  logic             dir_in,
    input  logic             eot_n,
    input  logic             dma_strobe,
    input  logic             dma_ack,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             pkt_short,
    input  logic [SEL_W-1:0] buf_sel,
    output logic             dma_active,
    output logic             dma_stop,
    output logic [NBUF-1:0]  flush_out,
    output logic [NBUF-1:0]  commit_in
);
    eot_cause_t       cause;
    ep_dir_e          dir;
    logic             beat;
    logic             pin_fall;
    logic [1:0]       step;
    logic [LVL_W-1:0] step_l;

    assign dir    = dir_in ? DIR_IN : DIR_OUT;
    assign step   = beat_step(width16);
    assign step_l = {{(LVL_W-2){1'b0}}, step};
    assign beat   = dma_strobe & dma_ack & dma_active;

    dma_eot_sync #(.STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (eot_n),
        .fall  (pin_fall)
    );

    dma_eot_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (cnt_load),
        .init   (cnt_init),
        .beat   (beat),
        .step   (step),
        .enable (cnt_en),
        .hit    (cause.cnt_hit)
    );

    assign cause.ext_hit = pin_fall;
    assign cause.shp_hit = short_en & (dir == DIR_OUT) & pkt_short & beat
                         & (fifo_level <= step_l);

    dma_eot_action #(.NBUF(NBUF), .LVL_W(LVL_W)) u_act (
        .clk    (clk),
        .rst    (rst),
        .dma_en (dma_en),
        .cause  (cause),
        .dir    (dir),
        .sel    (buf_sel),
        .level  (fifo_level),
        .beat   (beat),
        .step   (step),
        .active (dma_active),
        .stop   (dma_stop),
        .flush  (flush_out),
        .commit (commit_in)
    );
endmodule

// File: rtl/dma_eot_term_chk.sv
module dma_eot_term_chk #(
    parameter int NBUF = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            dma_en,
    input logic            dir_in,
    input logic            dma_active,
    input logic            dma_stop,
    input logic [NBUF-1:0] flush_out,
    input logic [NBUF-1:0] commit_in
);
    assert_single_stop_R5: assert property (@(posedge clk) disable iff (rst)
        dma_stop |=> !dma_stop);

    assert_idle_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
        dma_stop |-> !dma_active);

    assert_no_stop_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        !dma_en |=> !dma_stop);

    assert_in_commit_R7: assert property (@(posedge clk) disable iff (rst)
        (dma_stop && $past(dir_in)) |-> ($countones(commit_in) == 1 && flush_out == '0));

    assert_out_no_commit_R6: assert property (@(posedge clk) disable iff (rst)
        (dma_stop && !$past(dir_in)) |-> (commit_in == '0 && $onehot0(flush_out)));

    assert_action_needs_stop_R6: assert property (@(posedge clk) disable iff (rst)
        ((|flush_out) || (|commit_in)) |-> dma_stop);
endmodule

bind dma_eot_term dma_eot_term_chk #(.NBUF(NBUF)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dma_en     (dma_en),
    .dir_in     (dir_in),
    .dma_active (dma_active),
    .dma_stop   (dma_stop),
    .flush_out  (flush_out),
    .commit_in  (commit_in)
);

// File: tb/dma_eot_term_bench.sv
module dma_eot_term_bench;
    localparam int CNT_W = 16;
    localparam int LVL_W = 11;
    localparam int NBUF  = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             dma_en = 0, width16 = 0, cnt_en = 0, cnt_load = 0;
    logic [CNT_W-1:0] cnt_init = '0;
    logic             short_en = 0, dir_in = 0, eot_n = 1;
    logic             dma_strobe = 0, dma_ack = 0, pkt_short = 0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic [0:0]       buf_sel = '0;
    logic             dma_active, dma_stop;
    logic [NBUF-1:0]  flush_out, commit_in;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_eot_term #(.CNT_W(CNT_W), .LVL_W(LVL_W), .NBUF(NBUF)) u_dma_eot_term (
        .clk(clk), .rst(rst), .dma_en(dma_en), .width16(width16),
        .cnt_en(cnt_en), .cnt_load(cnt_load), .cnt_init(cnt_init),
        .short_en(short_en), .dir_in(dir_in), .eot_n(eot_n),
        .dma_strobe(dma_strobe), .dma_ack(dma_ack), .fifo_level(fifo_level),
        .pkt_short(pkt_short), .buf_sel(buf_sel), .dma_active(dma_active),
        .dma_stop(dma_stop), .flush_out(flush_out), .commit_in(commit_in)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic beat(input bit on);
        dma_strobe = on;
        dma_ack    = on;
    endtask

    // drop enable for one clock (re-arm), then set it
    task automatic rearm();
        dma_en = 0;
        tick();
        dma_en = 1;
    endtask

    task automatic run_cnt(input bit w, input int n, input bit bs, input bit din);
        int st, k;
        st = w ? 2 : 1;
        k  = (n + st - 1) / st;
        dma_en = 0; cnt_load = 1; cnt_init = CNT_W'(n); cnt_en = 1;
        width16 = w; short_en = 0; dir_in = din; buf_sel = bs;
        fifo_level = 20; beat(0);
        tick();
        cnt_load = 0; dma_en = 1;
        tick();
        chk("R9 active", int'(dma_active), 1);
        for (int i = 1; i <= k; i++) begin
            beat(1);
            tick();
            if (i < k) chk("R2 early stop", int'(dma_stop), 0);
            else begin
                chk("R2 terminal stop", int'(dma_stop), 1);
                chk("R6 flush", int'(flush_out), din ? 0 : (1 << bs));
                chk("R7 commit", int'(commit_in), din ? (1 << bs) : 0);
            end
        end
        tick();
        chk("R5 no second stop", int'(dma_stop), 0);
        chk("R5 inactive", int'(dma_active), 0);
        beat(0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R9 stop", int'(dma_stop), 0);
        chk("R9 flush", int'(flush_out), 0);
        chk("R9 commit", int'(commit_in), 0);
        chk("R9 idle", int'(dma_active), 0);

        // R2 / R6 / R7 sweep
        for (int w = 0; w < 2; w++)
            for (int n = 1; n <= 6; n++)
                for (int bs = 0; bs < 2; bs++)
                    for (int d = 0; d < 2; d++)
                        run_cnt(w[0], n, bs[0], d[0]);

        // R6 residue zero vs one
        run_cnt_resid(2, 0);
        run_cnt_resid(3, 1);

        // R3 counter disabled
        dma_en = 0; cnt_load = 1; cnt_init = 1; width16 = 0; cnt_en = 0;
        tick();
        cnt_load = 0; dma_en = 1; beat(1);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R3 no counter stop", int'(dma_stop), 0);
        end
        beat(0);

        // R4 short packet, 8-bit
        rearm(); cnt_en = 0; short_en = 1; pkt_short = 1; dir_in = 0;
        width16 = 0; buf_sel = 1;
        tick();
        for (int lv = 3; lv >= 1; lv--) begin
            fifo_level = LVL_W'(lv); beat(1);
            tick();
            chk("R4 short 8b", int'(dma_stop), lv == 1);
        end
        chk("R6 no flush drained", int'(flush_out), 0);
        beat(0);
        // R4 short packet, 16-bit
        rearm(); width16 = 1;
        fifo_level = 4; beat(1); tick();
        chk("R4 short 16b early", int'(dma_stop), 0);
        fifo_level = 2; tick();
        chk("R4 short 16b end", int'(dma_stop), 1);
        beat(0);
        // R4 ignored when mode off
        rearm(); width16 = 0; short_en = 0; fifo_level = 1; beat(1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 mode off", int'(dma_stop), 0);
        end
        // R4 ignored for IN
        short_en = 1; dir_in = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 IN ignored", int'(dma_stop), 0);
        end
        beat(0); short_en = 0; pkt_short = 0;

        // R1 external edge, IN endpoint, buffer 1
        rearm(); dir_in = 1; buf_sel = 1; cnt_en = 0;
        tick();
        eot_n = 0;
        tick(); chk("R1 sync 1", int'(dma_stop), 0);
        tick(); chk("R1 sync 2", int'(dma_stop), 0);
        tick(); chk("R1 stop", int'(dma_stop), 1);
        chk("R7 commit ext", int'(commit_in), 2);
        tick(); chk("R1 one pulse", int'(dma_stop), 0);
        rearm();
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R1 held low", int'(dma_stop), 0);
        end
        eot_n = 1;
        repeat (3) tick();

        // R5 coincident causes
        dma_en = 0; cnt_load = 1; cnt_init = 1; cnt_en = 1; width16 = 0;
        dir_in = 0; buf_sel = 0; fifo_level = 5;
        tick();
        cnt_load = 0; dma_en = 1;
        tick();
        eot_n = 0;
        tick(); tick();
        beat(1);
        tick(); chk("R5 merged stop", int'(dma_stop), 1);
        chk("R6 flush merged", int'(flush_out), 1);
        tick(); chk("R5 single pulse", int'(dma_stop), 0);
        beat(0); eot_n = 1;
        repeat (3) tick();

        // R8 disabled
        dma_en = 0; cnt_load = 1; cnt_init = 2; cnt_en = 1; width16 = 0;
        tick();
        cnt_load = 0; beat(1); eot_n = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R8 no stop", int'(dma_stop), 0);
            chk("R8 inactive", int'(dma_active), 0);
        end
        dma_en = 1;
        tick(); chk("R8 count kept 1", int'(dma_stop), 0);
        tick(); chk("R8 count kept 2", int'(dma_stop), 1);
        beat(0); eot_n = 1; dma_en = 0;
        repeat (3) tick();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    task automatic run_cnt_resid(input int lvl, input bit expect_flush);
        dma_en = 0; cnt_load = 1; cnt_init = 2; cnt_en = 1; width16 = 1;
        short_en = 0; dir_in = 0; buf_sel = 1; fifo_level = LVL_W'(lvl);
        tick();
        cnt_load = 0; dma_en = 1;
        tick();
        beat(1);
        tick();
        chk("R6 resid stop", int'(dma_stop), 1);
        chk("R6 resid flush", int'(flush_out), expect_flush ? 2 : 0);
        beat(0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule